// File: doc/BRIEF.md
# Change-Qualified Sample Capture Buffer

This block is an on-chip debug recorder. It watches a vector of probe signals, for example a data bus grouped with its valid, enable and reset lines, and writes a sample into a small internal memory only when that sample qualifies. A sample qualifies when any probe bit differs from its value one clock earlier. It also qualifies, when the periodic source is enabled, on every 2^k-th clock of a free-running tick counter. Because quiet stretches of the probes are not stored, a memory of limited depth covers a much longer span of activity.

Every stored entry carries a free-running timestamp and a flag that marks a timestamp wrap since the previous entry. The sparse record can therefore be expanded offline back into cycle-accurate timing. Capture runs while the arm input is high. Raising arm restarts the record at address 0. After arm is lowered, the memory is read back through a one-cycle-latency address/data port that shares the single memory port with the writer.

Top module: `chgcap_top`

## Requirements
- R1: While armed, a clock at which one or more probe bits differ from their values on the immediately preceding clock stores one entry. Each bit is compared on its own, across the full probe width, whether or not the earlier sample was stored.
- R2: While armed with the periodic source disabled, a clock at which the probe equals its previous-clock value stores nothing, and `fill_o` holds.
- R3: With `per_en_i` high, a clock also qualifies when the low `per_k_i` bits of a free-running tick counter are all zero. The counter is cleared by reset and advances every clock, so the period is 2^k and k = 0 stores every clock. The tick counter value is never stored.
- R4: The first clock at which `arm_i` is seen high after being low always stores. That entry goes to address 0 and leaves `fill_o` at 1, discarding the previous record.
- R5: An entry is `{timestamp[TS_W-1:0], wrap, probe[PROBE_W-1:0]}`, with the timestamp in the top bits and the probe in the low bits. The timestamp is a counter cleared by reset that advances every clock, and the stored value is the one present at the storing clock edge.
- R6: The wrap bit (entry bit PROBE_W) is 1 when the timestamp passed from its all-ones value to zero after the previous stored entry. It is 0 on the first entry after arming.
- R7: Once DEPTH entries are stored, no further entry is written, `full_o` is high and `fill_o` stays at DEPTH until the next arming.
- R8: `fill_o` equals the number of entries stored since the last arming and does not change while disarmed.
- R9: While `arm_i` is low, `rd_data_o` presents the entry at `rd_addr_i` one clock after the address is applied. While `arm_i` is high, `rd_data_o` holds its value.
- R10: After reset, `fill_o` is 0, `full_o` is 0 and `rd_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| probe_i | input | PROBE_W | Probe vector under observation |
| arm_i | input | 1 | Capture enable; its rising level restarts the record |
| per_en_i | input | 1 | Enables the periodic qualification source |
| per_k_i | input | clog2(PER_MAX+1) | Periodic exponent k, period 2^k clocks |
| rd_addr_i | input | clog2(DEPTH) | Readback address |
| rd_data_o | output | TS_W+1+PROBE_W | Readback entry {timestamp, wrap, probe} |
| fill_o | output | clog2(DEPTH+1) | Entries stored since arming |
| full_o | output | 1 | All DEPTH entries used |

## Verification
The bench builds the block with an 8-bit probe, a 16-entry memory, a 6-bit timestamp and a maximum exponent of 3. With these values, filling the memory takes only a few dozen clocks, and a quiet stretch of 70 clocks forces a timestamp wrap between two entries. Every periodic exponent from 0 to 3, including store-every-clock, is exercised in a short run. Random probe runs with long unchanged stretches are replayed against an entry-by-entry model of the expected record, including timestamps and wrap flags.

// File: rtl/chgcap_pkg.sv
`timescale 1ns/1ps
package chgcap_pkg;

    // Registered view of the arm input, used to spot the start of a capture.
    typedef enum logic {
        ARM_OFF = 1'b0,
        ARM_ON  = 1'b1
    } arm_state_e;

    // True when the lowest k bits of cnt are all zero (k = 0 is always true).
    function automatic logic low_bits_clear(input logic [31:0] cnt,
                                            input int unsigned k);
        logic [31:0] mask;
        if (k >= 32) begin
            mask = '1;
        end else begin
            mask = (32'd1 << k) - 32'd1;
        end
        return (cnt & mask) == 32'd0;
    endfunction

endpackage

// File: rtl/chgcap_qualify.sv
`timescale 1ns/1ps
module chgcap_qualify
    import chgcap_pkg::*;
#(
    parameter int PROBE_W = 8,
    parameter int PER_MAX = 7,
    parameter int KSEL_W  = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [PROBE_W-1:0] probe_i,
    input  logic               per_en_i,
    input  logic [KSEL_W-1:0]  per_k_i,
    output logic               qual_o
);

    typedef struct packed {
        logic [PROBE_W-1:0] prev;
        logic [PER_MAX-1:0] tick_cnt;
    } qual_state_t;

    qual_state_t s_d, s_q;
    logic [PROBE_W-1:0] bit_diff;
    logic               change;
    logic               tick;

    // One difference flag per probe bit, then OR-reduced.
    for (genvar b = 0; b < PROBE_W; b++) begin : g_bitcmp
        assign bit_diff[b] = probe_i[b] ^ s_q.prev[b];
    end

    always_comb begin
        s_d          = s_q;
        s_d.prev     = probe_i;
        s_d.tick_cnt = s_q.tick_cnt + 1'b1;
        change       = |bit_diff;
        tick         = per_en_i && low_bits_clear(32'(s_q.tick_cnt), 32'(per_k_i));
        qual_o       = change | tick;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/chgcap_stamp.sv
`timescale 1ns/1ps
module chgcap_stamp #(
    parameter int TS_W = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            store_i,
    input  logic            start_i,
    output logic [TS_W-1:0] ts_o,
    output logic            wrap_o
);

    typedef struct packed {
        logic [TS_W-1:0] ts;
        logic            wrap_pend;
    } stamp_state_t;

    stamp_state_t s_d, s_q;
    logic         at_top;

    always_comb begin
        s_d    = s_q;
        at_top = &s_q.ts;
        s_d.ts = s_q.ts + 1'b1;
        if (store_i) begin
            s_d.wrap_pend = at_top;
        end else begin
            s_d.wrap_pend = s_q.wrap_pend | at_top;
        end
        ts_o   = s_q.ts;
        wrap_o = start_i ? 1'b0 : s_q.wrap_pend;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/chgcap_store.sv
`timescale 1ns/1ps
module chgcap_store
    import chgcap_pkg::*;
#(
    parameter int ENTRY_W = 25,
    parameter int DEPTH   = 64,
    localparam int AW     = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               arm_i,
    input  logic               qual_i,
    input  logic [ENTRY_W-1:0] wdata_i,
    input  logic [AW-1:0]      rd_addr_i,
    output logic               start_o,
    output logic               store_o,
    output logic [CNT_W-1:0]   fill_o,
    output logic               full_o,
    output logic [ENTRY_W-1:0] rd_data_o
);

    typedef struct packed {
        arm_state_e         arm;
        logic [CNT_W-1:0]   fill;
        logic [ENTRY_W-1:0] rdata;
    } store_state_t;

    store_state_t       s_d, s_q;
    logic [ENTRY_W-1:0] mem_q [DEPTH];
    logic [CNT_W-1:0]   base;
    logic [AW-1:0]      waddr;
    logic               room;

    always_comb begin
        s_d     = s_q;
        s_d.arm = arm_i ? ARM_ON : ARM_OFF;
        start_o = arm_i && (s_q.arm == ARM_OFF);
        base    = start_o ? '0 : s_q.fill;
        room    = base < CNT_W'(DEPTH);
        store_o = arm_i && (start_o || qual_i) && room;
        waddr   = base[AW-1:0];
        if (arm_i) begin
            s_d.fill = base + CNT_W'(store_o);
        end else begin
            // Single memory port: reads are served only while disarmed.
            s_d.rdata = mem_q[rd_addr_i];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{arm: ARM_OFF, fill: '0, rdata: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (store_o) begin
            mem_q[waddr] <= wdata_i;
        end
    end

    assign fill_o    = s_q.fill;
    assign full_o    = (s_q.fill == CNT_W'(DEPTH));
    assign rd_data_o = s_q.rdata;

endmodule

// File: rtl/chgcap_top.sv
`timescale 1ns/1ps
module chgcap_top #(
    parameter int PROBE_W = 8,
    parameter int DEPTH   = 64,
    parameter int TS_W    = 16,
    parameter int PER_MAX = 7
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [PROBE_W-1:0]             probe_i,
    input  logic                           arm_i,
    input  logic                           per_en_i,
    input  logic [$clog2(PER_MAX+1)-1:0]   per_k_i,
    input  logic [$clog2(DEPTH)-1:0]       rd_addr_i,
    output logic [TS_W+PROBE_W:0]          rd_data_o,
    output logic [$clog2(DEPTH+1)-1:0]     fill_o,
    output logic                           full_o
);

    localparam int KSEL_W  = $clog2(PER_MAX + 1);
    localparam int ENTRY_W = TS_W + 1 + PROBE_W;

    logic                qual;
    logic                start;
    logic                store;
    logic [TS_W-1:0]     ts;
    logic                wrap;
    logic [ENTRY_W-1:0]  wdata;

    chgcap_qualify #(
        .PROBE_W (PROBE_W),
        .PER_MAX (PER_MAX),
        .KSEL_W  (KSEL_W)
    ) u_qualify (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .probe_i  (probe_i),
        .per_en_i (per_en_i),
        .per_k_i  (per_k_i),
        .qual_o   (qual)
    );

    chgcap_stamp #(
        .TS_W (TS_W)
    ) u_stamp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .store_i (store),
        .start_i (start),
        .ts_o    (ts),
        .wrap_o  (wrap)
    );

    assign wdata = {ts, wrap, probe_i};

    chgcap_store #(
        .ENTRY_W (ENTRY_W),
        .DEPTH   (DEPTH)
    ) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .arm_i     (arm_i),
        .qual_i    (qual),
        .wdata_i   (wdata),
        .rd_addr_i (rd_addr_i),
        .start_o   (start),
        .store_o   (store),
        .fill_o    (fill_o),
        .full_o    (full_o),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/chgcap_checker.sv
`timescale 1ns/1ps
module chgcap_checker #(
    parameter int PROBE_W = 8,
    parameter int DEPTH   = 64,
    parameter int TS_W    = 16,
    parameter int PER_MAX = 7,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic [PROBE_W-1:0]       probe_i,
    input logic                     arm_i,
    input logic                     per_en_i,
    input logic [TS_W+PROBE_W:0]    rd_data_o,
    input logic [CNT_W-1:0]         fill_o,
    input logic                     full_o
);

    p_change_stores_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm_i && $past(arm_i) && !full_o && (probe_i != $past(probe_i)))
        |=> (fill_o == $past(fill_o) + 1'b1));

    p_quiet_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm_i && $past(arm_i) && !per_en_i && (probe_i == $past(probe_i)))
        |=> $stable(fill_o));

    p_arm_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm_i && !$past(arm_i)) |=> (fill_o == CNT_W'(1)));

    p_full_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && arm_i && $past(arm_i)) |=> (full_o && $stable(fill_o)));

    p_fill_bounded_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_o <= CNT_W'(DEPTH));

    p_disarmed_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm_i |=> $stable(fill_o));

    p_rd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |=> $stable(rd_data_o));

endmodule

bind chgcap_top chgcap_checker #(
    .PROBE_W (PROBE_W),
    .DEPTH   (DEPTH),
    .TS_W    (TS_W),
    .PER_MAX (PER_MAX)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .probe_i   (probe_i),
    .arm_i     (arm_i),
    .per_en_i  (per_en_i),
    .rd_data_o (rd_data_o),
    .fill_o    (fill_o),
    .full_o    (full_o)
);

// File: tb/chgcap_top_tb.sv
`timescale 1ns/1ps
module chgcap_top_tb;

    localparam int PW = 8;
    localparam int DP = 16;
    localparam int TW = 6;
    localparam int PM = 3;
    localparam int EW = TW + 1 + PW;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic [PW-1:0] probe = '0;
    logic          arm = 1'b0;
    logic          per_en = 1'b0;
    logic [1:0]    per_k = '0;
    logic [3:0]    rd_addr = '0;
    logic [EW-1:0] rd_data;
    logic [4:0]    fill;
    logic          full;

    always #2 clk = ~clk;

    chgcap_top #(.PROBE_W(PW), .DEPTH(DP), .TS_W(TW), .PER_MAX(PM)) u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_ni),
        .probe_i   (probe),
        .arm_i     (arm),
        .per_en_i  (per_en),
        .per_k_i   (per_k),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .fill_o    (fill),
        .full_o    (full)
    );

    // Reference model state and scoreboard queue
    logic [PW-1:0] m_prev;
    logic          m_arm;
    logic          m_wp;
    int            m_fill;
    logic [TW-1:0] m_ts;
    logic [PM-1:0] m_pcnt;
    logic [EW-1:0] exp_q[$];
    logic [PW-1:0] cur;
    logic          g_pe;
    logic [1:0]    g_k;
    logic [3:0]    g_ra;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Driver: applies one clock of stimulus and predicts its effect.
    task automatic step(input logic [PW-1:0] p, input logic a);
        logic st, q, sto, w;
        int   base;
        int   mask;
        @(negedge clk);
        probe = p; arm = a; per_en = g_pe; per_k = g_k; rd_addr = g_ra;
        cur = p;
        mask = (1 << g_k) - 1;
        st   = a && !m_arm;
        q    = st || (p != m_prev) || (g_pe && ((int'(m_pcnt) & mask) == 0));
        base = st ? 0 : m_fill;
        sto  = a && q && (base < DP);
        w    = st ? 1'b0 : m_wp;
        if (sto) exp_q.push_back({m_ts, w, p});
        if (a) m_fill = base + (sto ? 1 : 0);
        m_wp   = sto ? (m_ts == '1) : (m_wp | (m_ts == '1));
        m_prev = p;
        m_ts   = m_ts + 1'b1;
        m_pcnt = m_pcnt + 1'b1;
        m_arm  = a;
        @(posedge clk); #1;
        check("R8 fill count", int'(fill), m_fill);
        check("R7 full flag", int'(full), int'(m_fill == DP));
    endtask

    // Monitor: reads the record back and pops expected entries in order.
    task automatic drain(input string tag);
        int n;
        logic [EW-1:0] e;
        n = m_fill;
        check("R8 queued vs fill", exp_q.size(), n);
        for (int i = 0; i < n; i++) begin
            g_ra = 4'(i);
            step(cur, 1'b0);
            e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
            check(tag, int'(rd_data), int'(e));
        end
        exp_q.delete();
        g_ra = '0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung, expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [EW-1:0] held;
        g_pe = 0; g_k = 0; g_ra = 0; cur = 0;
        repeat (4) @(posedge clk);
        #1;
        check("R10 reset fill", int'(fill), 0);
        check("R10 reset full", int'(full), 0);
        check("R10 reset rd_data", int'(rd_data), 0);
        @(negedge clk);
        rst_ni = 1'b1;
        m_prev = '0; m_arm = 0; m_wp = 0; m_fill = 0; m_ts = 1; m_pcnt = 1;

        // R4 / R2 / R1: arming, quiet hold, multi-bit and single-bit changes
        step(8'h00, 1'b1);
        check("R4 first armed clock stores", int'(fill), 1);
        repeat (3) step(8'h00, 1'b1);
        check("R2 quiet probe stores nothing", int'(fill), 1);
        step(8'hA5, 1'b1);
        check("R1 bus change stored", int'(fill), 2);
        step(8'hA5, 1'b1);
        check("R2 repeat value ignored", int'(fill), 2);
        step(8'h5A, 1'b1);
        step(8'h5B, 1'b1);
        check("R1 single bit change stored", int'(fill), 4);
        step(8'h5B, 1'b1);
        step(8'h80, 1'b1);
        step(8'h7F, 1'b1);
        check("R1 return-swing changes stored", int'(fill), 6);
        step(cur, 1'b0);
        drain("R5 entry layout and timestamp");

        // R3: periodic source with several exponents
        g_pe = 1; g_k = 2;
        repeat (12) step(8'h11, 1'b1);
        step(cur, 1'b0);
        drain("R3 periodic k=2 entries");
        g_pe = 1; g_k = 0;
        repeat (5) step(8'h11, 1'b1);
        check("R3 k=0 stores every clock", int'(fill), 5);
        step(cur, 1'b0);
        drain("R3 periodic k=0 entries");
        g_pe = 1; g_k = 3;
        repeat (20) step(8'h12, 1'b1);
        step(cur, 1'b0);
        drain("R3 periodic k=3 entries");
        g_pe = 1; g_k = 1;
        repeat (9) step(8'h13, 1'b1);
        step(cur, 1'b0);
        drain("R3 periodic k=1 entries");

        // R6: timestamp wrap across a long quiet stretch
        g_pe = 0;
        repeat (70) step(8'h22, 1'b1);
        step(8'h23, 1'b1);
        check("R6 quiet span stored two", int'(fill), 2);
        g_ra = 4'd1;
        step(cur, 1'b0);
        check("R6 wrap bit set", int'(rd_data[PW]), 1);
        g_ra = 4'd0;
        step(cur, 1'b0);
        check("R6 first entry wrap clear", int'(rd_data[PW]), 0);
        drain("R6 wrap entries");

        // R7: fill up and stop
        for (int i = 0; i < 25; i++) step(8'(i + 1), 1'b1);
        check("R7 full after depth", int'(full), 1);
        check("R7 fill saturates", int'(fill), DP);
        step(cur, 1'b0);
        drain("R7 first depth entries kept");

        // R9: readback frozen while armed
        held = rd_data;
        g_ra = 4'd3;
        for (int i = 0; i < 5; i++) begin
            step(8'(8'h40 + i), 1'b1);
            check("R9 rd_data held while armed", int'(rd_data), int'(held));
        end
        g_ra = 4'd0;
        step(cur, 1'b0);
        drain("R9 readback after rearm");

        // R1 with random probes and long unchanged stretches
        for (int r = 0; r < 8; r++) begin
            g_pe = 1'($urandom_range(0, 1));
            g_k  = 2'($urandom_range(0, 3));
            for (int i = 0; i < 40; i++) begin
                if ($urandom_range(0, 7) == 0) step(8'($urandom), 1'b1);
                else step(cur, 1'b1);
            end
            step(cur, 1'b0);
            drain("R1 random record");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule